// File: doc/BRIEF.md
# Banked Configuration Register Window

The block puts fourteen configuration registers for a two-channel disk controller behind one byte-wide pointer register and one word-wide data port. The host first writes the pointer to choose a channel bank and a register index. It then reads or writes the data port, which reaches the register that the pointer selects. The pointer also holds three global bus-timing controls. It can optionally advance the index after every data access, so that a whole bank can be loaded by streaming words to the data port.

Each bank holds seven registers. Two are word-wide base addresses, three are byte-wide configuration and timing bytes, and two are write-only read-ahead controls. Every stored field is driven on an output so that the rest of the controller can use it. One of the write-only bits is not stored. It produces a single-cycle pulse that empties the read-ahead FIFO of its channel. Pointer and data accesses are single-cycle strobes. Read data is combinational from the current pointer.

Top module: `cfg_window_regs`

## Requirements
- R1: After reset, the pointer reads 0x50. This means auto-advance off, posted-write wait on, burst-disable off, medium DEVSEL, bank 0 and index 0. Index 0 resets to 0x01F0 in bank 0 and to 0x0170 in bank 1. Index 4 resets to 0x03F6 in bank 0 and to 0x0376 in bank 1. Index 1 resets to 0x01, index 5 to 0xF5, and the read-ahead state to zero. The per-bank field orders are given in R3 and R4.
- R2: The pointer byte is laid out as follows: bit 7 auto-advance, bit 6 posted-write wait, bit 5 burst disable, bit 4 medium DEVSEL, bit 3 bank, bits 2-0 index. A pointer write stores all of these bits and drives post_wait, burst_off and devsel_medium from bits 6, 5 and 4. Bit 5 is write-only and always reads back as 0.
- R3: Index 0 (command base) and index 4 (control base) store all 16 bits of a data write and read back the same value. On the flat outputs, bank 1 sits in the upper half.
- R4: Index 1 (general config), index 5 (data timing) and index 6 (command timing) store the low byte of a data write. They read back with the upper byte zero. Index 6 resets to 0xDE.
- R5: Index 2 stores read-ahead count bits 7-0. Index 3 takes bit 7 as read-ahead enable, bit 4 as mode-4 enable and bits 1-0 as count bits 9-8. Both registers read as zero, and their fields appear on ra_count, ra_enable and mode4_en.
- R6: A write to index 3 with bit 6 set raises fifo_clr for that bank for exactly the one cycle after the write. The bit is not stored.
- R7: A data access reaches only the bank that pointer bit 3 selects. The other bank keeps its contents.
- R8: With pointer bit 7 set, each data read or write to index 0 to 6 advances the index by one after the access. Index 6 wraps to 0. The bank bit does not change.
- R9: With pointer bit 7 clear, data accesses leave the pointer unchanged.
- R10: When the index is 7, the data port reads as zero, a write changes no register, and the index does not advance.
- R11: A pointer write in the same cycle as a data access loads the written pointer value and does not advance it. The data access uses the pointer value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | Pointer write value |
| ptr_rdata | output | 8 | Pointer readback |
| dat_wr | input | 1 | Data port write strobe |
| dat_rd | input | 1 | Data port read strobe (advances the index) |
| dat_wdata | input | 16 | Data port write value |
| dat_rdata | output | 16 | Selected register value |
| post_wait | output | 1 | Posted-write wait-state control |
| burst_off | output | 1 | Master burst disable |
| devsel_medium | output | 1 | Medium DEVSEL timing |
| cmd_base | output | 32 | Command block base, bank1:bank0 |
| ctl_base | output | 32 | Control block base, bank1:bank0 |
| gen_cfg | output | 16 | General config bytes, bank1:bank0 |
| data_timing | output | 16 | Data port timing bytes, bank1:bank0 |
| cmd_timing | output | 16 | Command port timing bytes, bank1:bank0 |
| ra_count | output | 20 | 10-bit read-ahead counts, bank1:bank0 |
| ra_enable | output | 2 | Read-ahead enable per bank |
| mode4_en | output | 2 | Mode-4 timing enable per bank |
| fifo_clr | output | 2 | One-cycle FIFO clear pulse per bank |

## Verification
A wrong pointer index shows up in the cycle after the access that produced it. It appears on ptr_rdata, and the next data read returns the wrong register. A write that lands in the wrong bank or at the wrong index corrupts one of the flat field outputs on the next clock edge. The bench compares every field output with its model after each operation, so such a fault is caught within one operation. A FIFO clear pulse that is missing, stuck or repeated differs from the model one cycle after the write to index 3.

// File: rtl/cfg_window_regs.sv
module cfg_window_regs #(
  parameter logic [15:0] CMD_RST0 = 16'h01F0,
  parameter logic [15:0] CMD_RST1 = 16'h0170,
  parameter logic [15:0] CTL_RST0 = 16'h03F6,
  parameter logic [15:0] CTL_RST1 = 16'h0376,
  parameter logic [7:0]  GEN_RST  = 8'h01,
  parameter logic [7:0]  DTIM_RST = 8'hF5,
  parameter logic [7:0]  CTIM_RST = 8'hDE,
  parameter logic [7:0]  PTR_RST  = 8'h50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_wr,
  input  logic [7:0]  ptr_wdata,
  output logic [7:0]  ptr_rdata,
  input  logic        dat_wr,
  input  logic        dat_rd,
  input  logic [15:0] dat_wdata,
  output logic [15:0] dat_rdata,
  output logic        post_wait,
  output logic        burst_off,
  output logic        devsel_medium,
  output logic [31:0] cmd_base,
  output logic [31:0] ctl_base,
  output logic [15:0] gen_cfg,
  output logic [15:0] data_timing,
  output logic [15:0] cmd_timing,
  output logic [19:0] ra_count,
  output logic [1:0]  ra_enable,
  output logic [1:0]  mode4_en,
  output logic [1:0]  fifo_clr
);
  localparam logic [2:0] LAST_IDX = 3'd6;

  logic [7:0]  ptr_q;
  logic [15:0] cmd_q [2];
  logic [15:0] ctl_q [2];
  logic [7:0]  gen_q [2];
  logic [7:0]  dt_q  [2];
  logic [7:0]  ct_q  [2];
  logic [9:0]  ra_q  [2];
  logic [1:0]  raen_q, m4_q, clr_q;

  wire [2:0] idx   = ptr_q[2:0];
  wire       bank  = ptr_q[3];
  wire       valid = (idx <= LAST_IDX);
  wire       acc   = (dat_wr | dat_rd) & valid;
  wire       wr    = dat_wr & valid;
  wire [2:0] nxt   = (idx == LAST_IDX) ? 3'd0 : idx + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= PTR_RST;
      cmd_q[0] <= CMD_RST0; cmd_q[1] <= CMD_RST1;
      ctl_q[0] <= CTL_RST0; ctl_q[1] <= CTL_RST1;
      gen_q[0] <= GEN_RST;  gen_q[1] <= GEN_RST;
      dt_q[0]  <= DTIM_RST; dt_q[1]  <= DTIM_RST;
      ct_q[0]  <= CTIM_RST; ct_q[1]  <= CTIM_RST;
      ra_q[0]  <= '0;       ra_q[1]  <= '0;
      raen_q <= '0;
      m4_q   <= '0;
      clr_q  <= '0;
    end else begin
      clr_q <= '0;
      if (ptr_wr)
        ptr_q <= ptr_wdata;
      else if (acc && ptr_q[7])
        ptr_q[2:0] <= nxt;
      if (wr) begin
        case (idx)
          3'd0: cmd_q[bank] <= dat_wdata;
          3'd1: gen_q[bank] <= dat_wdata[7:0];
          3'd2: ra_q[bank][7:0] <= dat_wdata[7:0];
          3'd3: begin
            raen_q[bank]     <= dat_wdata[7];
            clr_q[bank]      <= dat_wdata[6];
            m4_q[bank]       <= dat_wdata[4];
            ra_q[bank][9:8]  <= dat_wdata[1:0];
          end
          3'd4: ctl_q[bank] <= dat_wdata;
          3'd5: dt_q[bank]  <= dat_wdata[7:0];
          3'd6: ct_q[bank]  <= dat_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      3'd0:    dat_rdata = cmd_q[bank];
      3'd1:    dat_rdata = {8'h00, gen_q[bank]};
      3'd4:    dat_rdata = ctl_q[bank];
      3'd5:    dat_rdata = {8'h00, dt_q[bank]};
      3'd6:    dat_rdata = {8'h00, ct_q[bank]};
      default: dat_rdata = 16'h0000;
    endcase
  end

  assign ptr_rdata     = {ptr_q[7:6], 1'b0, ptr_q[4:0]};
  assign post_wait     = ptr_q[6];
  assign burst_off     = ptr_q[5];
  assign devsel_medium = ptr_q[4];
  assign cmd_base      = {cmd_q[1], cmd_q[0]};
  assign ctl_base      = {ctl_q[1], ctl_q[0]};
  assign gen_cfg       = {gen_q[1], gen_q[0]};
  assign data_timing   = {dt_q[1], dt_q[0]};
  assign cmd_timing    = {ct_q[1], ct_q[0]};
  assign ra_count      = {ra_q[1], ra_q[0]};
  assign ra_enable     = raen_q;
  assign mode4_en      = m4_q;
  assign fifo_clr      = clr_q;
endmodule

module cfg_window_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ptr_wr,
  input logic [7:0]  ptr_wdata,
  input logic        dat_wr,
  input logic        dat_rd,
  input logic [15:0] dat_wdata,
  input logic [7:0]  ptr_rdata,
  input logic [15:0] dat_rdata,
  input logic [1:0]  fifo_clr
);
  wire       any_acc = dat_wr | dat_rd;
  wire [2:0] cur_idx = ptr_rdata[2:0];

  // R2
  burst_bit_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rdata[5] == 1'b0);

  // R8
  index_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !ptr_wr && ptr_rdata[7] && cur_idx < 3'd6)
      |=> ptr_rdata[2:0] == $past(cur_idx) + 3'd1);

  // R8
  index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !ptr_wr && ptr_rdata[7] && cur_idx == 3'd6)
      |=> ptr_rdata[2:0] == 3'd0);

  // R9
  pointer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !ptr_rdata[7]) |=> $stable(ptr_rdata));

  // R11
  pointer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_rdata == {$past(ptr_wdata[7:6]), 1'b0, $past(ptr_wdata[4:0])});

  // R10
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx == 3'd7 |-> dat_rdata == 16'h0000);

  // R10
  hole_no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx == 3'd7 && !ptr_wr) |=> $stable(ptr_rdata));

  // R5
  write_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx == 3'd2 || cur_idx == 3'd3) |-> dat_rdata == 16'h0000);

  // R6
  clear_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 3'd3 && dat_wdata[6])
      |=> fifo_clr == (ptr_rdata[3] ? 2'b10 : 2'b01) || $past(ptr_rdata[3]) != ptr_rdata[3]
          || fifo_clr == ($past(ptr_rdata[3]) ? 2'b10 : 2'b01));

  // R6
  clear_pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && cur_idx == 3'd3 && dat_wdata[6]) |=> fifo_clr == 2'b00);
endmodule

bind cfg_window_regs cfg_window_regs_chk u_chk (.*);

// File: tb/cfg_window_regs_bench.sv
module cfg_window_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr = 1'b0;
  logic [7:0]  ptr_wdata = '0;
  logic        dat_wr = 1'b0;
  logic        dat_rd = 1'b0;
  logic [15:0] dat_wdata = '0;
  logic [7:0]  ptr_rdata;
  logic [15:0] dat_rdata;
  logic        post_wait, burst_off, devsel_medium;
  logic [31:0] cmd_base, ctl_base;
  logic [15:0] gen_cfg, data_timing, cmd_timing;
  logic [19:0] ra_count;
  logic [1:0]  ra_enable, mode4_en, fifo_clr;

  always #10 clk = ~clk;

  cfg_window_regs u_cfg_window_regs (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  m_ptr;
  logic [15:0] m_cmd [2];
  logic [15:0] m_ctl [2];
  logic [7:0]  m_gen [2];
  logic [7:0]  m_dt  [2];
  logic [7:0]  m_ct  [2];
  logic [9:0]  m_ra  [2];
  logic [1:0]  m_raen, m_m4, m_clr;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read();
    logic b = m_ptr[3];
    case (m_ptr[2:0])
      3'd0: return m_cmd[b];
      3'd1: return {8'h00, m_gen[b]};
      3'd4: return m_ctl[b];
      3'd5: return {8'h00, m_dt[b]};
      3'd6: return {8'h00, m_ct[b]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_ptr = 8'h50;
    m_cmd[0] = 16'h01F0; m_cmd[1] = 16'h0170;
    m_ctl[0] = 16'h03F6; m_ctl[1] = 16'h0376;
    m_gen[0] = 8'h01; m_gen[1] = 8'h01;
    m_dt[0] = 8'hF5; m_dt[1] = 8'hF5;
    m_ct[0] = 8'hDE; m_ct[1] = 8'hDE;
    m_ra[0] = '0; m_ra[1] = '0;
    m_raen = '0; m_m4 = '0; m_clr = '0;
  endtask

  task automatic model_access(bit is_wr, logic [15:0] v);
    logic b = m_ptr[3];
    if (m_ptr[2:0] == 3'd7) return;
    if (is_wr) begin
      case (m_ptr[2:0])
        3'd0: m_cmd[b] = v;
        3'd1: m_gen[b] = v[7:0];
        3'd2: m_ra[b][7:0] = v[7:0];
        3'd3: begin m_raen[b] = v[7]; m_clr[b] = v[6]; m_m4[b] = v[4]; m_ra[b][9:8] = v[1:0]; end
        3'd4: m_ctl[b] = v;
        3'd5: m_dt[b] = v[7:0];
        default: m_ct[b] = v[7:0];
      endcase
    end
    if (m_ptr[7]) m_ptr[2:0] = (m_ptr[2:0] == 3'd6) ? 3'd0 : m_ptr[2:0] + 3'd1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ptr_write(logic [7:0] v);
    ptr_wr = 1'b1; ptr_wdata = v;
    m_clr = '0;
    step();
    ptr_wr = 1'b0;
    m_ptr = v;
  endtask

  task automatic dat_write(logic [15:0] v);
    dat_wr = 1'b1; dat_wdata = v;
    m_clr = '0;
    model_access(1'b1, v);
    step();
    dat_wr = 1'b0;
  endtask

  task automatic dat_read(string tag);
    dat_rd = 1'b1;
    m_clr = '0;
    #1 check(tag, dat_rdata, model_read());
    model_access(1'b0, 16'h0);
    step();
    dat_rd = 1'b0;
  endtask

  task automatic cmp_all(string tag);
    check({tag, " ptr"}, ptr_rdata, {m_ptr[7:6], 1'b0, m_ptr[4:0]});
    check({tag, " ctrl"}, {post_wait, burst_off, devsel_medium}, {m_ptr[6], m_ptr[5], m_ptr[4]});
    check({tag, " cmd_base"}, cmd_base, {m_cmd[1], m_cmd[0]});
    check({tag, " ctl_base"}, ctl_base, {m_ctl[1], m_ctl[0]});
    check({tag, " gen_cfg"}, gen_cfg, {m_gen[1], m_gen[0]});
    check({tag, " timing"}, {data_timing, cmd_timing}, {m_dt[1], m_dt[0], m_ct[1], m_ct[0]});
    check({tag, " ra_count"}, ra_count, {m_ra[1], m_ra[0]});
    check({tag, " ra_flags"}, {ra_enable, mode4_en}, {m_raen, m_m4});
    check({tag, " fifo_clr"}, fifo_clr, m_clr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cmp_all("R1");
    dat_read("R1 idx0 bank0");
    ptr_write(8'h0C);
    dat_read("R1 idx4 bank1");

    // R3 word registers and bank-specific reset
    ptr_write(8'h00);
    dat_write(16'hA5C3);
    dat_read("R3 idx0 write");
    ptr_write(8'h08);
    dat_read("R3 idx0 bank1 reset");
    // R7 bank isolation
    check("R7 bank0 kept", cmd_base[15:0], 16'hA5C3);
    ptr_write(8'h04);
    dat_write(16'h1234);
    cmp_all("R7");

    // R4 byte registers
    ptr_write(8'h01);
    dat_write(16'hBEEF);
    dat_read("R4 idx1");
    ptr_write(8'h0E);
    dat_read("R4 idx6 reset");
    dat_write(16'h5A3C);
    dat_read("R4 idx6 write");

    // R5 and R6 write-only registers, clear pulse
    ptr_write(8'h02);
    dat_write(16'h1234);
    dat_read("R5 idx2 zero");
    check("R5 count low", ra_count[7:0], 8'h34);
    ptr_write(8'h03);
    dat_write(16'h00D2);
    check("R6 pulse", fifo_clr, 2'b01);
    cmp_all("R5");
    step();
    m_clr = '0;
    check("R6 pulse gone", fifo_clr, 2'b00);
    dat_read("R5 idx3 zero");

    // R2 pointer fields
    ptr_write(8'h6A);
    check("R2 readback", ptr_rdata, 8'h4A);
    check("R2 burst_off", burst_off, 1'b1);
    check("R2 devsel", devsel_medium, 1'b0);

    // R8 auto-advance with wrap
    ptr_write(8'h85);
    dat_read("R8 idx5");
    check("R8 advance", ptr_rdata, 8'h86);
    dat_write(16'h0077);
    check("R8 wrap", ptr_rdata, 8'h80);
    dat_read("R8 idx0 after wrap");
    check("R8 step", ptr_rdata, 8'h81);

    // R9 no advance
    ptr_write(8'h05);
    dat_read("R9 read a");
    dat_read("R9 read b");
    check("R9 hold", ptr_rdata, 8'h05);

    // R10 index 7 hole
    ptr_write(8'h8F);
    dat_write(16'hFFFF);
    check("R10 no advance", ptr_rdata, 8'h8F);
    dat_read("R10 zero read");
    cmp_all("R10");

    // R11 pointer write collides with data access
    ptr_write(8'h81);
    ptr_wr = 1'b1; ptr_wdata = 8'h84; dat_wr = 1'b1; dat_wdata = 16'h00AB;
    m_gen[0] = 8'hAB; m_clr = '0;
    step();
    ptr_wr = 1'b0; dat_wr = 1'b0;
    m_ptr = 8'h84;
    check("R11 pointer", ptr_rdata, 8'h84);
    cmp_all("R11");

    // random traffic, R7 R8 R2 against the model
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      if (op == 0) ptr_write(8'($urandom));
      else if (op <= 2) dat_write(16'($urandom));
      else dat_read("R7 random read");
      cmp_all("R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule